// File: doc/BRIEF.md
# Smart Card Clock Generator

This block produces the clock for the clock contact of a smart card and a second clock for external devices. It runs from a crystal-rate reference clock and sees a slow oscillator signal from elsewhere on the chip. Configuration inputs select the card clock source and its divisor, and the auxiliary clock rate. The card clock can be an integer division of the reference or a synchronously doubled version of that division, can follow the slow oscillator for card power-saving, or can be stopped at a chosen level.

All changes to the card clock take effect only on a phase boundary of the card clock itself. No source, divisor or stop change can cut a phase short. The shortest phase is a parameter, so the card clock can be kept under its frequency ceiling for any reference rate.

Top module: `scc_card_clock`

## Requirements
- R1: While `rst_n` is low and after it is released, the card clock is LOW and stays LOW while `cfg_mode` holds the low-stop code, and the auxiliary clock runs at one quarter of the reference.
- R2: With `cfg_mode` = 0 (run), `cfg_dbl` = 0 and a divisor code D, every card clock phase lasts D+1 reference cycles, as long as that value is at least MIN_HALF.
- R3: In run mode, `cfg_dbl` = 1 sets the phase length to (D+1)>>1 and `cfg_dbl` = 2 sets it to (D+1)>>2. Code 3 acts like code 2.
- R4: A computed phase length below MIN_HALF is raised to MIN_HALF reference cycles, which limits the card clock to at most the reference rate divided by 2*MIN_HALF.
- R5: With `cfg_mode` = 2 (stop low), the phase in progress finishes at its full length, then the card clock goes LOW and holds there.
- R6: With `cfg_mode` = 3 (stop high), the phase in progress finishes, then the card clock goes HIGH and holds there.
- R7: On leaving a stop mode, the first card clock phase after the leaving edge has the full length of the new setting.
- R8: With `cfg_mode` = 1 (slow), the card clock toggles once for each edge, rising or falling, of the synchronised `slow_osc`. Each phase then equals one slow half-period.
- R9: No card clock phase is ever shorter than MIN_HALF reference cycles, including across every mode and divisor change.
- R10: A divisor or doubling change made during a phase does not alter that phase. The new length applies from the next phase.
- R11: `cfg_aux` selects the auxiliary clock: 0 gives the reference itself, 1 gives half, 2 and 3 give one quarter. The selection changes only while every candidate is LOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_osc | input | 1 | Slow internal oscillator signal (asynchronous) |
| cfg_mode | input | 2 | Card clock source: 0 run, 1 slow, 2 stop low, 3 stop high |
| cfg_div | input | DIV_W | Divisor code D, base phase length D+1 |
| cfg_dbl | input | 2 | Doubling steps: 0, 1, 2 (3 acts as 2) |
| cfg_aux | input | 2 | Auxiliary rate: 0 full, 1 half, 2/3 quarter |
| card_clk | output | 1 | Clock to the card contact |
| aux_clk | output | 1 | Clock for external devices |

## Verification
The hardest case to reach is a configuration change that arrives partway through a card clock phase. The first phase of a new setting, after a stop or a slow-mode interval, is also hard to observe in isolation. The stimulus waits for an observed card clock edge, queues the expected phase lengths, and only then changes the configuration. This places the change inside a known phase, so the remaining part of the old phase and the first full new phase are measured separately. Entry into slow mode skips two edges before measuring, because the first slow phase depends on where the oscillator edge falls.

// File: rtl/scc_pkg.sv
package scc_pkg;
   typedef enum logic [1:0] {
      CK_RUN     = 2'd0,
      CK_SLOW    = 2'd1,
      CK_STOP_LO = 2'd2,
      CK_STOP_HI = 2'd3
   } ck_mode_e;

   typedef enum logic [1:0] {
      AUX_FULL  = 2'd0,
      AUX_HALF  = 2'd1,
      AUX_QUART = 2'd2,
      AUX_QALT  = 2'd3
   } aux_sel_e;
endpackage

// File: rtl/scc_edge_sync.sv
module scc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_p
);
   logic [STAGES-1:0] sh;
   logic              prev;

   if (STAGES < 1) begin : g_bad_stages
      $error("scc_edge_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= din;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], din};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= sh[STAGES-1];
   end

   assign edge_p = sh[STAGES-1] ^ prev;
endmodule

// File: rtl/scc_phase_ctrl.sv
module scc_phase_ctrl
   import scc_pkg::*;
#(
   parameter int DIV_W    = 4,
   parameter int MIN_HALF = 2,
   localparam int CW      = DIV_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_edge,
   input  ck_mode_e         cfg_mode,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [1:0]       cfg_dbl,
   output logic             card_clk,
   output ck_mode_e         act_mode,
   output logic [CW-1:0]    act_half
);
   localparam logic [CW-1:0] MIN_LEN  = CW'(MIN_HALF);
   localparam logic [CW-1:0] MIN_LAST = CW'(MIN_HALF - 1);
   localparam logic [CW-1:0] CNT_MAX  = '1;

   logic [CW-1:0] cnt;
   logic          pend;
   logic          done;
   logic          lvl_nxt;
   logic [CW-1:0] half_nxt;

   function automatic logic [CW-1:0] f_half(input logic [DIV_W-1:0] d,
                                            input logic [1:0] s);
      logic [CW-1:0] h;
      logic [1:0]    sh;
      sh = (s == 2'd3) ? 2'd2 : s;
      h  = ({1'b0, d} + 1'b1) >> sh;
      if (h < MIN_LEN) h = MIN_LEN;
      return h;
   endfunction

   always_comb begin
      unique case (act_mode)
         CK_RUN:  done = (cnt >= act_half - 1'b1);
         CK_SLOW: done = (pend || slow_edge) && (cnt >= MIN_LAST);
         default: done = (cnt >= MIN_LAST);
      endcase
   end

   always_comb begin
      unique case (cfg_mode)
         CK_STOP_LO: lvl_nxt = 1'b0;
         CK_STOP_HI: lvl_nxt = 1'b1;
         default:    lvl_nxt = ~card_clk;
      endcase
      half_nxt = f_half(cfg_div, cfg_dbl);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_clk <= 1'b0;
         act_mode <= CK_STOP_LO;
         act_half <= MIN_LEN;
         cnt      <= '0;
      end else if (done) begin
         card_clk <= lvl_nxt;
         act_mode <= cfg_mode;
         act_half <= half_nxt;
         cnt      <= '0;
      end else if (cnt != CNT_MAX) begin
         cnt      <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                pend <= 1'b0;
      else if (done)                             pend <= 1'b0;
      else if (slow_edge && act_mode == CK_SLOW) pend <= 1'b1;
   end
endmodule

// File: rtl/scc_aux_div.sv
module scc_aux_div
   import scc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_sel,
   output logic       aux_clk
);
   logic [1:0] q;
   aux_sel_e   sel_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= q + 1'b1;
   end

   // switch on the falling reference edge while all candidates are low
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)          sel_r <= AUX_QUART;
      else if (q == 2'd0)  sel_r <= aux_sel_e'(cfg_sel);
   end

   always_comb begin
      unique case (sel_r)
         AUX_FULL: aux_clk = clk;
         AUX_HALF: aux_clk = q[0];
         default:  aux_clk = q[1];
      endcase
   end
endmodule

// File: rtl/scc_card_clock.sv
module scc_card_clock
   import scc_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int MIN_HALF    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_osc,
   input  logic [1:0]       cfg_mode,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [1:0]       cfg_dbl,
   input  logic [1:0]       cfg_aux,
   output logic             card_clk,
   output logic             aux_clk
);
   localparam int CW = DIV_W + 1;

   if (DIV_W < 2) begin : g_bad_div
      $error("scc_card_clock: DIV_W must be at least 2");
   end
   if (MIN_HALF < 1 || MIN_HALF > (1 << DIV_W)) begin : g_bad_min
      $error("scc_card_clock: MIN_HALF out of range");
   end

   logic          slow_edge;
   ck_mode_e      act_mode;
   logic [CW-1:0] act_half;

   scc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (slow_osc),
      .edge_p (slow_edge)
   );

   scc_phase_ctrl #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_edge (slow_edge),
      .cfg_mode  (ck_mode_e'(cfg_mode)),
      .cfg_div   (cfg_div),
      .cfg_dbl   (cfg_dbl),
      .card_clk  (card_clk),
      .act_mode  (act_mode),
      .act_half  (act_half)
   );

   scc_aux_div u_aux (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_sel (cfg_aux),
      .aux_clk (aux_clk)
   );
endmodule

// File: rtl/scc_card_clock_chk.sv
module scc_card_clock_chk
   import scc_pkg::*;
#(
   parameter int DIV_W    = 4,
   parameter int MIN_HALF = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             card_clk,
   input ck_mode_e         act_mode,
   input logic [DIV_W:0]   act_half
);
   localparam int RW = DIV_W + 2;
   localparam logic [RW-1:0] RUN_MAX = '1;

   logic            card_d;
   logic [RW-1:0]   run;
   ck_mode_e        mode_d;
   logic [DIV_W:0]  half_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         card_d <= 1'b0;
         run    <= RW'(MIN_HALF);
         mode_d <= CK_STOP_LO;
         half_d <= (DIV_W+1)'(MIN_HALF);
      end else begin
         card_d <= card_clk;
         mode_d <= act_mode;
         half_d <= act_half;
         if (card_clk != card_d) run <= RW'(1);
         else if (run != RUN_MAX) run <= run + 1'b1;
      end
   end

   assert_min_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (card_clk != card_d) |-> (run >= RW'(MIN_HALF)));

   assert_run_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (card_clk != card_d && mode_d == CK_RUN) |-> (run == RW'(half_d)));

   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == CK_STOP_LO) |-> !card_clk);

   assert_hold_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode == CK_STOP_HI) |-> card_clk);
endmodule

bind scc_card_clock scc_card_clock_chk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .card_clk (card_clk),
   .act_mode (act_mode),
   .act_half (act_half)
);

// File: tb/tb_scc_card_clock.sv
module tb_scc_card_clock;
   localparam int DIV_W = 4;
   localparam int MIN_HALF = 2;
   localparam logic [1:0] M_RUN = 2'd0, M_SLOW = 2'd1, M_LO = 2'd2, M_HI = 2'd3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slow_osc = 1'b0;
   logic [1:0]       cfg_mode = M_LO;
   logic [DIV_W-1:0] cfg_div = 4'd3;
   logic [1:0]       cfg_dbl = 2'd0;
   logic [1:0]       cfg_aux = 2'd2;
   logic             card_clk;
   logic             aux_clk;

   int    n_chk = 0;
   int    n_fail = 0;
   int    runts = 0;
   int    exp_w[$];
   string exp_tag[$];
   logic  m_last = 1'b0;
   int    m_width = 0;

   always #5 clk = ~clk;
   initial forever #200 slow_osc = ~slow_osc;

   scc_card_clock #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) dut (
      .clk(clk), .rst_n(rst_n), .slow_osc(slow_osc), .cfg_mode(cfg_mode),
      .cfg_div(cfg_div), .cfg_dbl(cfg_dbl), .cfg_aux(cfg_aux),
      .card_clk(card_clk), .aux_clk(aux_clk));

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // monitor: measures each card clock phase, pops expected lengths
   always @(negedge clk) begin
      if (!rst_n) begin
         m_last  = card_clk;
         m_width = 0;
      end else if (card_clk !== m_last) begin
         if (m_width < MIN_HALF) runts++;
         if (exp_w.size() > 0) begin
            int    e;
            string t;
            e = exp_w.pop_front();
            t = exp_tag.pop_front();
            chk(m_width == e, t, m_width, e);
         end
         m_width = 1;
         m_last  = card_clk;
      end else begin
         m_width++;
      end
   end

   task automatic set_cfg(input logic [1:0] m, input int d, input int s);
      @(negedge clk);
      cfg_mode = m;
      cfg_div  = DIV_W'(d);
      cfg_dbl  = 2'(s);
   endtask

   task automatic wait_toggle();
      logic p;
      p = card_clk;
      do @(negedge clk); while (card_clk === p);
   endtask

   task automatic push_exp(input int w, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_w.push_back(w);
         exp_tag.push_back(tag);
      end
   endtask

   task automatic drain();
      while (exp_w.size() != 0) @(negedge clk);
   endtask

   // driver: skip transitional edges, then queue steady phase lengths
   task automatic expect_steady(input int skip, input int w, input int n, input string tag);
      for (int i = 0; i < skip; i++) wait_toggle();
      @(negedge clk);
      push_exp(w, n, tag);
      drain();
   endtask

   task automatic count_toggles(input int cycles, output int t);
      logic p;
      t = 0;
      p = card_clk;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (card_clk !== p) t++;
         p = card_clk;
      end
   endtask

   task automatic aux_rises(output int r);
      logic p;
      r = 0;
      @(negedge clk);
      #2 p = aux_clk;
      for (int i = 0; i < 16; i++) begin
         #5;
         if (aux_clk && !p) r++;
         p = aux_clk;
         #5;
         if (aux_clk && !p) r++;
         p = aux_clk;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int t;
      int r;
      repeat (4) @(negedge clk);
      chk(card_clk == 1'b0, "R1 card level in reset", int'(card_clk), 0);
      rst_n = 1'b1;
      count_toggles(30, t);
      chk(t == 0 && card_clk == 1'b0, "R1 card held low after reset", t, 0);
      aux_rises(r);
      chk(r == 4, "R1 aux at quarter after reset", r, 4);

      // R2 plain division
      set_cfg(M_RUN, 3, 0);
      expect_steady(1, 4, 6, "R2 div code 3");
      set_cfg(M_RUN, 7, 0);
      expect_steady(1, 8, 4, "R2 div code 7");

      // R3 doubling
      set_cfg(M_RUN, 11, 1);
      expect_steady(1, 6, 4, "R3 one doubling");
      set_cfg(M_RUN, 11, 2);
      expect_steady(1, 3, 4, "R3 two doublings");
      set_cfg(M_RUN, 11, 3);
      expect_steady(1, 3, 4, "R3 code 3 as 2");

      // R4 clamp to MIN_HALF
      set_cfg(M_RUN, 0, 0);
      expect_steady(1, 2, 4, "R4 div code 0 clamped");
      set_cfg(M_RUN, 3, 2);
      expect_steady(1, 2, 4, "R4 doubled below floor");

      // R10 mid-phase divisor change
      set_cfg(M_RUN, 7, 0);
      expect_steady(1, 8, 2, "R10 setup");
      wait_toggle();
      @(negedge clk);
      push_exp(8, 1, "R10 current phase keeps old length");
      push_exp(2, 2, "R10 new length next phase");
      @(negedge clk);
      cfg_div = 4'd1;
      drain();

      // R5 stop low, requested during a high phase
      set_cfg(M_RUN, 7, 0);
      expect_steady(1, 8, 2, "R5 setup");
      while (card_clk !== 1'b1) wait_toggle();
      @(negedge clk);
      push_exp(8, 1, "R5 high phase completes");
      cfg_mode = M_LO;
      drain();
      count_toggles(50, t);
      chk(t == 0 && card_clk == 1'b0, "R5 held low", t, 0);

      // R7 resume from low stop
      set_cfg(M_RUN, 5, 0);
      expect_steady(1, 6, 3, "R7 first phase after low stop");

      // R6 stop high
      set_cfg(M_HI, 5, 0);
      repeat (30) @(negedge clk);
      count_toggles(50, t);
      chk(t == 0 && card_clk == 1'b1, "R6 held high", t, 0);
      set_cfg(M_RUN, 3, 0);
      expect_steady(1, 4, 2, "R7 first phase after high stop");

      // R8 slow oscillator mode
      set_cfg(M_SLOW, 3, 0);
      expect_steady(2, 20, 4, "R8 slow half period");
      set_cfg(M_RUN, 3, 0);
      expect_steady(1, 4, 3, "R8 leaving slow mode");

      // R11 auxiliary rates
      cfg_aux = 2'd0;
      repeat (8) @(negedge clk);
      aux_rises(r);
      chk(r == 16, "R11 aux full rate", r, 16);
      cfg_aux = 2'd1;
      repeat (8) @(negedge clk);
      aux_rises(r);
      chk(r == 8, "R11 aux half rate", r, 8);
      cfg_aux = 2'd3;
      repeat (8) @(negedge clk);
      aux_rises(r);
      chk(r == 4, "R11 aux code 3 quarter", r, 4);
      cfg_aux = 2'd2;
      repeat (8) @(negedge clk);
      aux_rises(r);
      chk(r == 4, "R11 aux quarter", r, 4);

      chk(runts == 0, "R9 phases shorter than floor", runts, 0);
      summary();
   end
endmodule